// File: doc/BRIEF.md
# Next-PC and Branch Unit

This unit holds the program counter and decides its value for the next step. On every step that is enabled, it picks one of four sources: the sequential address (PC + 4), a relative target (PC plus a sign-extended word offset times four), the link register, or the count register. The choice follows a 3-bit branch-kind code.

On the two linking forms, the unit also asks for a link-register write whose data is the address after the current one. A conditional relative branch tests one selected bit of a 4-bit condition field. A polarity input says whether the branch is taken when that bit is set or when it is clear. If the test fails, the PC falls through to PC + 4.

The register holding the PC uses an asynchronous active-low reset that loads a parameterised reset vector. The two least significant bits of every PC value are forced to zero, including values taken from the link and count registers. The unit does not fetch instructions, predict branches or decrement the count register.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted and after its release, `pc` equals `RESET_VEC` with bits [1:0] cleared. With the default vector 0x102, this value is 0x100.
- R2: When `step_en` is 0, `pc` keeps its value and `lr_we` is 0, whatever the branch inputs are.
- R3: Kind code 0 (sequential) sets the next `pc` to `pc` + 4, wrapping modulo 2^32. The offset input is ignored.
- R4: Kind code 1 (relative) sets the next `pc` to `pc` + sign_extend(`br_off`) * 4. A negative offset moves the PC backwards.
- R5: Kind code 2 (relative and link) takes the relative target of R4. In the same step it drives `lr_we`=1 and `lr_wdata` = `pc` + 4.
- R6: Kind code 3 (to link) loads the next `pc` from `lr_val` with bits [1:0] cleared.
- R7: Kind code 4 (to count) loads the next `pc` from `ctr_val` with bits [1:0] cleared.
- R8: Kind code 5 (to count and link) loads the next `pc` from `ctr_val` with bits [1:0] cleared. It also drives `lr_we`=1 and `lr_wdata` = `pc` + 4.
- R9: Kind code 6 (conditional) reads bit `cond_sel` of `cond_fld`. If that bit equals `cond_pol`, it takes the relative target of R4; otherwise the next `pc` is `pc` + 4. `cond_pol`=1 means branch if set; `cond_pol`=0 means branch if clear.
- R10: `lr_we` is 1 only for kind codes 2 and 5 on an enabled step. Kind code 7 is reserved and behaves as kind code 0.
- R11: Bits [1:0] of `pc` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advances the PC on this clock edge |
| br_kind | input | 3 | Branch-kind code |
| br_off | input | OFS_W (24) | Signed word offset |
| lr_val | input | PC_W (32) | Current link-register value |
| ctr_val | input | PC_W (32) | Current count-register value |
| cond_fld | input | CF_W (4) | Condition field |
| cond_sel | input | log2(CF_W) (2) | Index of the tested condition bit |
| cond_pol | input | 1 | 1: branch if the bit is set, 0: branch if it is clear |
| pc | output | PC_W (32) | Current program counter |
| npc | output | PC_W (32) | Next program counter for an enabled step |
| lr_we | output | 1 | Link-register write request |
| lr_wdata | output | PC_W (32) | Link-register write data (`pc` + 4) |

## Verification
The properties assume that `br_kind`, `lr_val` and `ctr_val` are stable and known around each clock edge. Transfer checks such as the link-target property compare against the sampled value of `lr_val` from the previous edge.

The bench changes every input only on the falling clock edge. Before each vector it places the PC at a known base address through a to-link step, so each vector starts from a defined PC. Offsets stay within the 24-bit signed range, and the condition index always falls inside the 4-bit field.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [2:0] {
    BK_SEQ      = 3'd0,
    BK_REL      = 3'd1,
    BK_REL_LINK = 3'd2,
    BK_TO_LR    = 3'd3,
    BK_TO_CTR   = 3'd4,
    BK_CTR_LINK = 3'd5,
    BK_COND     = 3'd6,
    BK_RSVD     = 3'd7
  } br_kind_e;

endpackage

// File: rtl/npc_targets.sv
// Computes every candidate next address in parallel.
module npc_targets #(
  parameter int PC_W  = 32,
  parameter int OFS_W = 24
) (
  input  logic [PC_W-1:0]  pc_cur,
  input  logic [OFS_W-1:0] off,
  input  logic [PC_W-1:0]  lr_in,
  input  logic [PC_W-1:0]  ctr_in,
  output logic [PC_W-1:0]  seq_t,
  output logic [PC_W-1:0]  rel_t,
  output logic [PC_W-1:0]  lr_t,
  output logic [PC_W-1:0]  ctr_t
);
  localparam int EXT_W = PC_W - OFS_W;

  logic [PC_W-1:0] off_ext;

  always_comb begin
    off_ext = {{EXT_W{off[OFS_W-1]}}, off};
    seq_t   = pc_cur + PC_W'(4);
    rel_t   = pc_cur + {off_ext[PC_W-3:0], 2'b00};
    lr_t    = {lr_in[PC_W-1:2], 2'b00};
    ctr_t   = {ctr_in[PC_W-1:2], 2'b00};
  end
endmodule

// File: rtl/npc_cond.sv
// Tests one selected condition bit against the requested polarity.
module npc_cond #(
  parameter int CF_W  = 4,
  localparam int SEL_W = $clog2(CF_W)
) (
  input  logic [CF_W-1:0]  fld,
  input  logic [SEL_W-1:0] sel,
  input  logic             pol,
  output logic             taken
);
  logic [CF_W-1:0] hit;

  for (genvar i = 0; i < CF_W; i++) begin : g_bit
    assign hit[i] = (sel == SEL_W'(i)) && (fld[i] == pol);
  end

  assign taken = |hit;
endmodule

// File: rtl/npc_select.sv
// Picks the next PC source and flags the linking forms.
module npc_select #(
  parameter int PC_W = 32
) (
  input  logic [2:0]      kind,
  input  logic            cond_ok,
  input  logic [PC_W-1:0] seq_t,
  input  logic [PC_W-1:0] rel_t,
  input  logic [PC_W-1:0] lr_t,
  input  logic [PC_W-1:0] ctr_t,
  output logic [PC_W-1:0] npc_o,
  output logic            link_o
);
  import npc_pkg::*;

  br_kind_e k;

  always_comb begin
    k      = br_kind_e'(kind);
    npc_o  = seq_t;
    link_o = 1'b0;
    case (k)
      BK_SEQ:      npc_o = seq_t;
      BK_REL:      npc_o = rel_t;
      BK_REL_LINK: begin npc_o = rel_t; link_o = 1'b1; end
      BK_TO_LR:    npc_o = lr_t;
      BK_TO_CTR:   npc_o = ctr_t;
      BK_CTR_LINK: begin npc_o = ctr_t; link_o = 1'b1; end
      BK_COND:     npc_o = cond_ok ? rel_t : seq_t;
      default:     npc_o = seq_t;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int              PC_W      = 32,
  parameter int              OFS_W     = 24,
  parameter int              CF_W      = 4,
  parameter logic [PC_W-1:0] RESET_VEC = 32'h0000_0102,
  localparam int             SEL_W     = $clog2(CF_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [2:0]       br_kind,
  input  logic [OFS_W-1:0] br_off,
  input  logic [PC_W-1:0]  lr_val,
  input  logic [PC_W-1:0]  ctr_val,
  input  logic [CF_W-1:0]  cond_fld,
  input  logic [SEL_W-1:0] cond_sel,
  input  logic             cond_pol,
  output logic [PC_W-1:0]  pc,
  output logic [PC_W-1:0]  npc,
  output logic             lr_we,
  output logic [PC_W-1:0]  lr_wdata
);
  localparam logic [PC_W-1:0] RST_PC = {RESET_VEC[PC_W-1:2], 2'b00};

  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] seq_t, rel_t, lr_t, ctr_t;
  logic            cond_ok, link;

  npc_targets #(.PC_W(PC_W), .OFS_W(OFS_W)) u_tgt (
    .pc_cur (pc_q),
    .off    (br_off),
    .lr_in  (lr_val),
    .ctr_in (ctr_val),
    .seq_t  (seq_t),
    .rel_t  (rel_t),
    .lr_t   (lr_t),
    .ctr_t  (ctr_t)
  );

  npc_cond #(.CF_W(CF_W)) u_cond (
    .fld   (cond_fld),
    .sel   (cond_sel),
    .pol   (cond_pol),
    .taken (cond_ok)
  );

  npc_select #(.PC_W(PC_W)) u_sel (
    .kind    (br_kind),
    .cond_ok (cond_ok),
    .seq_t   (seq_t),
    .rel_t   (rel_t),
    .lr_t    (lr_t),
    .ctr_t   (ctr_t),
    .npc_o   (npc),
    .link_o  (link)
  );

  // next-state
  always_comb begin
    pc_d = pc_q;
    if (step_en) pc_d = npc;
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RST_PC;
    else        pc_q <= pc_d;
  end

  assign pc       = pc_q;
  assign lr_we    = step_en & link;
  assign lr_wdata = seq_t;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step_en,
  input logic [2:0]      br_kind,
  input logic [PC_W-1:0] lr_val,
  input logic [PC_W-1:0] pc,
  input logic            lr_we,
  input logic [PC_W-1:0] lr_wdata
);
  // R11
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pc));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && br_kind == 3'd0) |=> pc == $past(pc) + PC_W'(4));

  // R6
  to_lr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && br_kind == 3'd3) |=> pc == {$past(lr_val[PC_W-1:2]), 2'b00});

  // R5
  link_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> lr_wdata == pc + PC_W'(4));

  // R10
  link_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> (step_en && (br_kind == 3'd2 || br_kind == 3'd5)));
endmodule

bind npc_unit npc_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .step_en  (step_en),
  .br_kind  (br_kind),
  .lr_val   (lr_val),
  .pc       (pc),
  .lr_we    (lr_we),
  .lr_wdata (lr_wdata)
);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en;
  logic [2:0]  br_kind;
  logic [23:0] br_off;
  logic [31:0] lr_val, ctr_val;
  logic [3:0]  cond_fld;
  logic [1:0]  cond_sel;
  logic        cond_pol;
  logic [31:0] pc, npc, lr_wdata;
  logic        lr_we;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] LRV  = 32'h0000_8001;
  localparam logic [31:0] CTRV = 32'h0001_2347;

  always #10 clk = ~clk;

  npc_unit u_npc_unit (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .br_kind(br_kind),
    .br_off(br_off), .lr_val(lr_val), .ctr_val(ctr_val),
    .cond_fld(cond_fld), .cond_sel(cond_sel), .cond_pol(cond_pol),
    .pc(pc), .npc(npc), .lr_we(lr_we), .lr_wdata(lr_wdata)
  );

  // fields: base(32) kind(3) off(24) fld(4) sel(2) pol(1) exp_pc(32) exp_we(1)
  localparam int NV = 13;
  localparam logic [98:0] VEC [NV] = '{
    {32'h0000_1000, 3'd0, 24'h000005, 4'h0, 2'd0, 1'b0, 32'h0000_1004, 1'b0}, // R3
    {32'h0000_1000, 3'd1, 24'h000010, 4'h0, 2'd0, 1'b0, 32'h0000_1040, 1'b0}, // R4
    {32'h0000_1000, 3'd1, 24'hFFFFFF, 4'h0, 2'd0, 1'b0, 32'h0000_0FFC, 1'b0}, // R4
    {32'h0000_2000, 3'd2, 24'h000004, 4'h0, 2'd0, 1'b0, 32'h0000_2010, 1'b1}, // R5
    {32'h0000_2000, 3'd3, 24'h000000, 4'h0, 2'd0, 1'b0, 32'h0000_8000, 1'b0}, // R6
    {32'h0000_2000, 3'd4, 24'h000000, 4'h0, 2'd0, 1'b0, 32'h0001_2344, 1'b0}, // R7
    {32'h0000_2000, 3'd5, 24'h000000, 4'h0, 2'd0, 1'b0, 32'h0001_2344, 1'b1}, // R8
    {32'h0000_3000, 3'd6, 24'h000008, 4'h4, 2'd2, 1'b1, 32'h0000_3020, 1'b0}, // R9
    {32'h0000_3000, 3'd6, 24'h000008, 4'h4, 2'd2, 1'b0, 32'h0000_3004, 1'b0}, // R9
    {32'h0000_3000, 3'd6, 24'h000008, 4'h4, 2'd1, 1'b0, 32'h0000_3020, 1'b0}, // R9
    {32'h0000_3000, 3'd6, 24'hFFFFFE, 4'hB, 2'd3, 1'b1, 32'h0000_2FF8, 1'b0}, // R9
    {32'h0000_3000, 3'd7, 24'h000008, 4'hF, 2'd0, 1'b1, 32'h0000_3004, 1'b0}, // R10
    {32'hFFFF_FFFC, 3'd0, 24'h000000, 4'h0, 2'd0, 1'b0, 32'h0000_0000, 1'b0}  // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [2:0] k, input logic [23:0] off,
                      input logic [31:0] lr, input logic [3:0] f,
                      input logic [1:0] s, input logic p);
    step_en = en; br_kind = k; br_off = off; lr_val = lr;
    cond_fld = f; cond_sel = s; cond_pol = p;
  endtask

  initial begin
    rst_n = 1'b0;
    step(1'b1, 3'd1, 24'h000100, LRV, 4'h0, 2'd0, 1'b0);
    ctr_val = CTRV;
    repeat (3) @(negedge clk);
    chk("R1 in reset", pc, 32'h0000_0100);
    rst_n = 1'b1;
    step(1'b0, 3'd0, 24'h0, LRV, 4'h0, 2'd0, 1'b0);
    @(negedge clk);
    chk("R1 after release", pc, 32'h0000_0100);

    for (int i = 0; i < NV; i++) begin
      logic [98:0] v;
      v = VEC[i];
      step(1'b1, 3'd3, 24'h0, v[98:67], 4'h0, 2'd0, 1'b0);
      @(posedge clk); @(negedge clk);
      step(1'b1, v[66:64], v[63:40], LRV, v[39:36], v[35:34], v[33]);
      #1;
      chk("R10 lr_we", {31'b0, lr_we}, {31'b0, v[0]});
      if (v[0]) chk("R5/R8 lr_wdata", lr_wdata, v[98:67] + 32'd4);
      @(posedge clk); @(negedge clk);
      chk($sformatf("R3-R9 vector %0d pc", i), pc, v[32:1]);
      chk("R11 alignment", {30'b0, pc[1:0]}, 32'h0);
    end

    // R2: disabled step ignores a linking branch
    step(1'b1, 3'd3, 24'h0, 32'h0000_4000, 4'h0, 2'd0, 1'b0);
    @(posedge clk); @(negedge clk);
    step(1'b0, 3'd2, 24'h000040, LRV, 4'hF, 2'd0, 1'b1);
    #1;
    chk("R2 lr_we off", {31'b0, lr_we}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R2 hold", pc, 32'h0000_4000);
    @(posedge clk); @(negedge clk);
    chk("R2 hold again", pc, 32'h0000_4000);

    // R1: reset mid-run returns to vector
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", pc, 32'h0000_0100);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule